// File: doc/BRIEF.md
# Floating-point condition compare unit

The unit compares two IEEE-754 operands and writes a one-bit answer into a small file of condition flags. Each compare arrives as a 32-bit instruction word, strobed by `valid_i`, with the two operand values. The word names the two source registers, a 5-bit condition, a precision and a destination flag. Single-precision compares use the low 32 bits of each 64-bit operand. Double-precision compares use all 64 bits.

The unit finds which one of four relations holds between the operands: less, equal, greater or unordered. The condition is turned into a 4-bit mask of accepted relations, and the result is 1 when the mask bit of the relation found is set. The lowest condition bit picks quiet or signaling NaN handling. That choice decides when the invalid-operation status is raised.

The result, the status outputs and the flag update all appear one cycle after the strobe. A word that is not a legal compare raises an illegal-instruction output and leaves every flag unchanged. The source register indices are decoded straight from the word without a register stage, so a surrounding register file can fetch the operands.

Top module: `fp_cond_cmp`

## Requirements
- R1: The relation found is exactly one of less, equal, greater or unordered. Any NaN operand gives unordered. Positive and negative zero compare equal. `result_o` is 1 when the mask bit for the relation found is set.
- R2: The mask is built from condition bits 4:1. Mask bit 0 (less) is set by condition bit 1 or bit 4. Mask bit 1 (equal) is set by condition bit 2. Mask bit 2 (unordered) is set by condition bit 3. Mask bit 3 (greater) is set by condition bit 4.
- R3: Condition bit 0 selects the compare type. When it is 0 (quiet), `invalid_o` is raised only if an operand is a signaling NaN. When it is 1 (signaling), `invalid_o` is raised if either operand is any NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and a fraction MSB of 0.
- R4: Instruction fields are: condition in bits 19:15, second source index in bits 14:10, first source index in bits 9:5, and destination flag in bits 2:0. `fj_idx_o` and `fk_idx_o` show bits 9:5 and 14:10 of `insn_i` combinationally.
- R5: Bits 31:20 equal to 0x0C1 select a single-precision compare on operand bits 31:0, with the upper bits ignored. Bits 31:20 equal to 0x0C2 select a double-precision compare.
- R6: A word whose bits 31:20 match neither opcode, or whose bits 4:3 are not 00, gives `illegal_o`=1 with `result_o`=0 and `invalid_o`=0, and leaves all flags unchanged.
- R7: `valid_o` is `valid_i` delayed by one cycle. When `valid_o` is 0, `result_o`, `invalid_o` and `illegal_o` are 0.
- R8: A legal compare writes its result into the flag selected by the destination field. The new value shows on `flags_o` together with `valid_o`, and the other seven flags keep their values.
- R9: While `rst_ni` is low, all flags and all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction and operands are valid |
| insn_i | input | 32 | Compare instruction word |
| src_a_i | input | 64 | First operand value |
| src_b_i | input | 64 | Second operand value |
| fj_idx_o | output | 5 | First source register index (combinational) |
| fk_idx_o | output | 5 | Second source register index (combinational) |
| valid_o | output | 1 | Registered outputs valid |
| result_o | output | 1 | Compare result |
| invalid_o | output | 1 | Invalid-operation status |
| illegal_o | output | 1 | Instruction word was not a legal compare |
| cd_o | output | 3 | Destination flag index of the reported compare |
| flags_o | output | 8 | Condition flag file |

## Verification
The bench builds the four relations from a sortable-key model and picks operands from a pool. The pool holds signed zeros, infinities, quiet and signaling NaNs, subnormals, equal pairs and negated pairs. If a design treated the two zeros as different, an equal condition on them would read 0. If a design mixed up the two NaN kinds, a quiet compare would wrongly raise invalid on a quiet NaN. Single-precision compares are given random upper operand bits, so a design that read those bits would return wrong relations. Illegal words and bits 4:3 that are not zero are mixed with legal compares; a design that still wrote on them would corrupt a flag that the bench's shadow copy keeps.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {REL_LT, REL_EQ, REL_GT, REL_UN} rel_e;

  localparam logic [11:0] OPC_SP = 12'h0C1;
  localparam logic [11:0] OPC_DP = 12'h0C2;

  // relation mask bit positions
  localparam int MSK_LT = 0;
  localparam int MSK_EQ = 1;
  localparam int MSK_UN = 2;
  localparam int MSK_GT = 3;

  typedef struct packed {
    logic [4:0] cond;
    logic [4:0] fk;
    logic [4:0] fj;
    logic [2:0] cd;
    logic       is_dp;
    logic       legal;
  } insn_dec_t;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
(
  input  logic [31:0] insn_i,
  output insn_dec_t   dec_o
);
  logic opc_sp, opc_dp;

  assign opc_sp = (insn_i[31:20] == OPC_SP);
  assign opc_dp = (insn_i[31:20] == OPC_DP);

  always_comb begin
    dec_o.cond  = insn_i[19:15];
    dec_o.fk    = insn_i[14:10];
    dec_o.fj    = insn_i[9:5];
    dec_o.cd    = insn_i[2:0];
    dec_o.is_dp = opc_dp;
    dec_o.legal = (opc_sp | opc_dp) & (insn_i[4:3] == 2'b00);
  end
endmodule

// File: rtl/fcc_rel_core.sv
module fcc_rel_core
  import fcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_e         rel_o,
  output logic         snan_o,
  output logic         nan_o
);
  logic [W-2:0] a_mag, b_mag;
  logic a_nan, b_nan, a_snan, b_snan, zeros, mag_lt;

  assign a_mag  = a_i[W-2:0];
  assign b_mag  = b_i[W-2:0];
  assign a_nan  = (&a_i[W-2:MAN_W]) & (|a_i[MAN_W-1:0]);
  assign b_nan  = (&b_i[W-2:MAN_W]) & (|b_i[MAN_W-1:0]);
  assign a_snan = a_nan & ~a_i[MAN_W-1];
  assign b_snan = b_nan & ~b_i[MAN_W-1];
  assign zeros  = ~(|a_mag) & ~(|b_mag);
  assign mag_lt = a_mag < b_mag;
  assign snan_o = a_snan | b_snan;
  assign nan_o  = a_nan | b_nan;

  always_comb begin
    if (nan_o)                       rel_o = REL_UN;
    else if (zeros || a_i == b_i)    rel_o = REL_EQ;
    else if (a_i[W-1] != b_i[W-1])   rel_o = a_i[W-1] ? REL_LT : REL_GT;
    else                             rel_o = (mag_lt ^ a_i[W-1]) ? REL_LT : REL_GT;
  end
endmodule

// File: rtl/fcc_flag_file.sv
module fcc_flag_file #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic          wdata_i,
  output logic [N-1:0]  flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flags_o[i] <= 1'b0;
      else if (we_i && widx_i == IW'(i))    flags_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
  import fcc_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  localparam int FW = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [31:0]          insn_i,
  input  logic [63:0]          src_a_i,
  input  logic [63:0]          src_b_i,
  output logic [4:0]           fj_idx_o,
  output logic [4:0]           fk_idx_o,
  output logic                 valid_o,
  output logic                 result_o,
  output logic                 invalid_o,
  output logic                 illegal_o,
  output logic [2:0]           cd_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  insn_dec_t dec;
  rel_e rel_sp, rel_dp, rel;
  logic snan_sp, snan_dp, nan_sp, nan_dp, snan, nan;
  logic [3:0] mask;
  logic hit, inv, wr;

  fcc_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  fcc_rel_core #(.EXP_W(8), .MAN_W(23)) u_sp (
    .a_i(src_a_i[31:0]), .b_i(src_b_i[31:0]),
    .rel_o(rel_sp), .snan_o(snan_sp), .nan_o(nan_sp));

  fcc_rel_core #(.EXP_W(11), .MAN_W(52)) u_dp (
    .a_i(src_a_i), .b_i(src_b_i),
    .rel_o(rel_dp), .snan_o(snan_dp), .nan_o(nan_dp));

  assign rel  = dec.is_dp ? rel_dp  : rel_sp;
  assign snan = dec.is_dp ? snan_dp : snan_sp;
  assign nan  = dec.is_dp ? nan_dp  : nan_sp;

  // not-equal bit covers less and greater
  always_comb begin
    mask         = '0;
    mask[MSK_LT] = dec.cond[1] | dec.cond[4];
    mask[MSK_EQ] = dec.cond[2];
    mask[MSK_UN] = dec.cond[3];
    mask[MSK_GT] = dec.cond[4];
  end

  always_comb begin
    unique case (rel)
      REL_LT:  hit = mask[MSK_LT];
      REL_EQ:  hit = mask[MSK_EQ];
      REL_GT:  hit = mask[MSK_GT];
      default: hit = mask[MSK_UN];
    endcase
  end

  assign inv      = dec.cond[0] ? nan : snan;
  assign wr       = valid_i & dec.legal;
  assign fj_idx_o = dec.fj;
  assign fk_idx_o = dec.fk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= 1'b0;
      invalid_o <= 1'b0;
      illegal_o <= 1'b0;
      cd_o      <= '0;
    end else begin
      valid_o   <= valid_i;
      result_o  <= wr & hit;
      invalid_o <= wr & inv;
      illegal_o <= valid_i & ~dec.legal;
      if (valid_i) cd_o <= dec.cd;
    end
  end

  fcc_flag_file #(.N(NUM_FLAGS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr),
    .widx_i(dec.cd[FW-1:0]), .wdata_i(hit), .flags_o(flags_o));
endmodule

// File: rtl/fp_cond_cmp_chk.sv
module fp_cond_cmp_chk #(
  parameter int NUM_FLAGS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 valid_o,
  input logic                 result_o,
  input logic                 invalid_o,
  input logic                 illegal_o,
  input logic [2:0]           cd_o,
  input logic [NUM_FLAGS-1:0] flags_o
);
  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_quiet_outs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !result_o && !invalid_o && !illegal_o);
  p_illegal_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> flags_o == $past(flags_o) && !result_o && !invalid_o);
  p_flag_written_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> flags_o[cd_o] == result_o);
  p_one_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_o ^ $past(flags_o)) <= 1);
  p_idle_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));
endmodule

bind fp_cond_cmp fp_cond_cmp_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .result_o(result_o), .invalid_o(invalid_o), .illegal_o(illegal_o),
  .cd_o(cd_o), .flags_o(flags_o));

// File: tb/fp_cond_cmp_tb_top.sv
module fp_cond_cmp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic [4:0]  fj_idx_o, fk_idx_o;
  logic        valid_o, result_o, invalid_o, illegal_o;
  logic [2:0]  cd_o;
  logic [7:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] shadow = '0;

  always #5 clk_i = ~clk_i;

  fp_cond_cmp dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // widened to 64 bits with single placed at the top so one key works
  function automatic int ref_rel(logic [63:0] a, logic [63:0] b, bit dp);
    logic [63:0] x, y, kx, ky, sg;
    bit xn, yn;
    sg = 64'h8000_0000_0000_0000;
    if (dp) begin
      x = a; y = b;
      xn = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      yn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    end else begin
      x = {a[31:0], 32'h0}; y = {b[31:0], 32'h0};
      xn = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      yn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    end
    if (xn || yn) return 3;
    if ((x & ~sg) == 0 && (y & ~sg) == 0) return 1;
    kx = x[63] ? ~x : (x | sg);
    ky = y[63] ? ~y : (y | sg);
    if (kx < ky) return 0;
    if (kx == ky) return 1;
    return 2;
  endfunction

  function automatic bit ref_hit(logic [4:0] c, int rel);
    case (rel)
      0: return c[1] | c[4];
      1: return c[2];
      2: return c[4];
      default: return c[3];
    endcase
  endfunction

  function automatic bit ref_inv(logic [63:0] a, logic [63:0] b, bit dp, bit sig);
    bit an, bn, as_, bs;
    if (dp) begin
      an = (a[62:52] == 11'h7FF) && (a[51:0] != 0); as_ = an && !a[51];
      bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0); bs = bn && !b[51];
    end else begin
      an = (a[30:23] == 8'hFF) && (a[22:0] != 0); as_ = an && !a[22];
      bn = (b[30:23] == 8'hFF) && (b[22:0] != 0); bs = bn && !b[22];
    end
    return sig ? (an | bn) : (as_ | bs);
  endfunction

  function automatic logic [31:0] mk(bit dp, logic [4:0] c, logic [4:0] fk,
                                     logic [4:0] fj, logic [2:0] cd);
    return {dp ? 12'h0C2 : 12'h0C1, c, fk, fj, 2'b00, cd};
  endfunction

  task automatic do_op(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    bit legal, dp, exp_res, exp_inv;
    int rel;
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = w; src_a_i = a; src_b_i = b;
    #1;
    check("R4 fj index", fj_idx_o, w[9:5]);
    check("R4 fk index", fk_idx_o, w[14:10]);
    dp = (w[31:20] == 12'h0C2);
    legal = (w[31:20] == 12'h0C1 || dp) && w[4:3] == 2'b00;
    rel = ref_rel(a, b, dp);
    exp_res = legal && ref_hit(w[19:15], rel);
    exp_inv = legal && ref_inv(a, b, dp, w[15]);
    if (legal) shadow[w[2:0]] = exp_res;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R7 valid", valid_o, 1);
    check("R1 R2 R5 result", result_o, exp_res);
    check("R3 invalid", invalid_o, exp_inv);
    check("R6 illegal", illegal_o, !legal);
    check("R8 flags", flags_o, shadow);
    if (legal) check("R4 cd", cd_o, w[2:0]);
  endtask

  function automatic logic [63:0] pick(int k, bit dp);
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    if (dp) case (k)
      0: return 64'h0;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF0_0000_0000_0000;
      3: return 64'hFFF0_0000_0000_0000;
      4: return 64'h7FF8_0000_0000_0001;
      5: return 64'h7FF0_0000_0000_0001;
      6: return {r[63], 11'h0, r[51:0]};
      7: return {r[63], 11'h3FF, r[51:0]};
      default: return r;
    endcase
    else case (k)
      0: return {r[63:32], 32'h0};
      1: return {r[63:32], 32'h8000_0000};
      2: return {r[63:32], 32'h7F80_0000};
      3: return {r[63:32], 32'hFF80_0000};
      4: return {r[63:32], 32'hFFC0_0003};
      5: return {r[63:32], 32'h7F80_0010};
      6: return {r[63:32], r[31], 8'h0, r[22:0]};
      7: return {r[63:32], r[31], 8'h7F, r[22:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #23;
    check("R9 flags in reset", flags_o, 0);
    check("R9 valid in reset", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 idle valid", valid_o, 0);

    // directed corners
    do_op(mk(1, 5'b00100, 5'd3, 5'd7, 3'd2), 64'h0, 64'h8000_0000_0000_0000); // R1 zeros equal
    do_op(mk(0, 5'b10000, 5'd1, 5'd2, 3'd5), 64'h3F80_0000, 64'hBF80_0000);   // R2 not-equal
    do_op(mk(0, 5'b00000, 5'd0, 5'd0, 3'd1), 64'h7F80_0001, 64'h0);           // R3 quiet sNaN
    do_op(mk(1, 5'b00000, 5'd0, 5'd0, 3'd1), 64'h7FF8_0000_0000_0000, 64'h0); // R3 quiet qNaN
    do_op(mk(1, 5'b01001, 5'd0, 5'd0, 3'd3), 64'h7FF8_0000_0000_0000, 64'h0); // R3 signaling qNaN
    do_op(mk(0, 5'b00010, 5'd4, 5'd4, 3'd7), 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000); // R5 low half
    do_op({12'h0C3, 5'b11110, 10'h0, 2'b00, 3'd2}, 64'h0, 64'h0);            // R6 bad opcode
    do_op({12'h0C1, 5'b11110, 10'h0, 2'b01, 3'd2}, 64'h0, 64'h0);            // R6 bad bits 4:3
    @(negedge clk_i);
    check("R7 idle after op", valid_o, 0);
    check("R8 idle flags", flags_o, shadow);

    for (int i = 0; i < 600; i++) begin
      bit dp;
      logic [31:0] w;
      logic [63:0] a, b;
      int m;
      dp = $urandom_range(0, 1);
      a = pick($urandom_range(0, 9), dp);
      m = $urandom_range(0, 9);
      if (m == 0) b = a;
      else if (m == 1) b = dp ? (a ^ 64'h8000_0000_0000_0000) : (a ^ 64'h8000_0000);
      else b = pick($urandom_range(0, 9), dp);
      w = mk(dp, 5'($urandom()), 5'($urandom()), 5'($urandom()), 3'($urandom()));
      if ($urandom_range(0, 9) == 0) w[4:3] = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 9) == 0) w[31:20] = 12'($urandom()) | 12'h400;
      do_op(w, a, b);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule